// File: doc/BRIEF.md
# Privilege and Interrupt-Enable Save/Restore Stack

This block keeps the current privilege mode of a hart together with the status fields that trap handling saves and restores: the global interrupt enables for machine and supervisor level, their saved copies, and the saved privilege that each level returns to. A trap entry pushes the current enable and mode into the saved fields of the target level. A return pops them back. Software can also write the fields directly through a single write port, and the block keeps only values that the configuration can actually hold.

Two build parameters select the modes that exist: `HAS_S` for supervisor and `HAS_U` for user. Machine mode is always present. Supervisor is treated as present only when user mode is present too. Fields that belong to an absent level read as zero. The saved machine privilege keeps only legal values, so software can find out which modes exist by writing a mode and reading it back. With only machine and user modes, that field is held in one flip-flop and reads as 0 or 3.

All control pins are plain single-cycle strobes. The block has no data stream and so no valid/ready handshake. Every event is accepted in the cycle it is presented, and it never stalls.

Top module: `priv_stack`

## Requirements
- R1: Modes are encoded U=0, S=1, M=3, and the value 2 is never legal. `status_rd` and `csr_wdata` share one layout: [1:0] saved machine privilege (MPP), [2] saved supervisor privilege (SPP, 1=S, 0=U), [3] MIE, [4] SIE, [5] MPIE, [6] SPIE. `priv_mode` only ever shows an implemented mode.
- R2: After reset, `priv_mode` is 3 and every enable and saved-enable bit is 0. SPP is 0. MPP holds the lowest implemented mode: 0 when user mode exists, otherwise 3.
- R3: A trap whose effective target is M does the following: MPIE takes MIE, MIE clears, MPP takes the current mode, and `priv_mode` becomes 3.
- R4: A trap with `trap_target`=1 goes to S only when supervisor mode exists and the current mode is not M. In that case SPIE takes SIE, SIE clears, SPP records whether the current mode was S, and `priv_mode` becomes 1. Any other trap is taken to M.
- R5: On `mret_req`, MIE takes MPIE, `priv_mode` takes MPP, MPIE sets, and MPP becomes U, or M when user mode is absent.
- R6: On `sret_req` with supervisor mode present, SIE takes SPIE, `priv_mode` becomes S if SPP=1 and U otherwise, SPIE sets, and SPP clears. Without supervisor mode, `sret_req` changes nothing.
- R7: A CSR write stores the written enable, saved-enable and SPP bits. A written MPP is kept only if it is an implemented mode. Otherwise the previous MPP is retained.
- R8: Without supervisor mode, SPP, SIE and SPIE read 0. Without user mode, MPP reads 3 whatever is written.
- R9: When events coincide, priority runs trap, then `mret_req`, then an effective `sret_req`, then the CSR write. The lower-priority events in that cycle are dropped. With no event, all state holds. Every result is visible after the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap entry strobe |
| trap_target | input | 2 | Requested trap mode (1 = S, anything else = M) |
| mret_req | input | 1 | Return-from-machine strobe |
| sret_req | input | 1 | Return-from-supervisor strobe |
| csr_we | input | 1 | Status field write strobe |
| csr_wdata | input | 7 | Field values to write (layout in R1) |
| priv_mode | output | 2 | Current privilege mode |
| status_rd | output | 7 | Readable field values (layout in R1) |

## Verification
Every result of this block is registered, and there is no pipeline. A trap, a return or a write presented before a rising edge shows on `priv_mode` and `status_rd` right after that edge, one cycle later. The bench therefore drives each stimulus on a falling edge, lets one rising edge pass, and compares at the next falling edge. The checker properties use `|=>` for the same one-cycle relation. The full, machine-plus-user and machine-only builds run side by side on shared stimulus, so that the legality and hardwired-zero rules can be compared within a single cycle.

// File: rtl/priv_stack_pkg.sv
package priv_stack_pkg;

  typedef enum logic [1:0] {
    MODE_U    = 2'd0,
    MODE_S    = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_M    = 2'd3
  } mode_e;

  localparam int unsigned STATUS_W = 7;

  // Shared layout of the write port and the read port, MSB first.
  typedef struct packed {
    logic       spie;
    logic       mpie;
    logic       sie;
    logic       mie;
    logic       spp;
    logic [1:0] mpp;
  } status_t;

  // True when the value names a mode that this build implements.
  function automatic logic mode_ok(input logic [1:0] m, input bit has_s, input bit has_u);
    logic ok;
    case (m)
      MODE_M:  ok = 1'b1;
      MODE_S:  ok = has_s;
      MODE_U:  ok = has_u;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/priv_stack_pplegal.sv
module priv_stack_pplegal
  import priv_stack_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic [1:0] wr_val,
  input  logic [1:0] cur,
  output logic [1:0] nxt
);

  // Keep the written mode only when it exists, otherwise hold the old one.
  always_comb begin
    if (mode_ok(wr_val, HAS_S, HAS_U)) nxt = wr_val;
    else                               nxt = cur;
  end

endmodule

// File: rtl/priv_stack_mlevel.sv
module priv_stack_mlevel
  import priv_stack_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_trap,
  input  logic       ev_ret,
  input  logic       ev_wr,
  input  logic [1:0] cur_priv,
  input  logic       wr_mie,
  input  logic       wr_mpie,
  input  logic [1:0] wr_mpp,
  output logic       mie,
  output logic       mpie,
  output logic [1:0] mpp
);

  // Mode that a return leaves behind, also the reset value.
  localparam logic [1:0] LOW_PP = HAS_U ? MODE_U : MODE_M;
  // Two storage bits only when three modes can be recorded.
  localparam bit WIDE_PP = HAS_S && HAS_U;

  logic [1:0] wr_legal;
  logic [1:0] mpp_nxt;

  priv_stack_pplegal #(
    .HAS_S (HAS_S),
    .HAS_U (HAS_U)
  ) u_legal (
    .wr_val (wr_mpp),
    .cur    (mpp),
    .nxt    (wr_legal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie  <= 1'b0;
      mpie <= 1'b0;
    end else if (ev_trap) begin
      mpie <= mie;
      mie  <= 1'b0;
    end else if (ev_ret) begin
      mie  <= mpie;
      mpie <= 1'b1;
    end else if (ev_wr) begin
      mie  <= wr_mie;
      mpie <= wr_mpie;
    end
  end

  always_comb begin
    if (ev_trap)     mpp_nxt = cur_priv;
    else if (ev_ret) mpp_nxt = LOW_PP;
    else if (ev_wr)  mpp_nxt = wr_legal;
    else             mpp_nxt = mpp;
  end

  generate
    if (WIDE_PP) begin : g_pp_wide
      logic [1:0] pp_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_q <= LOW_PP;
        else        pp_q <= mpp_nxt;
      end
      assign mpp = pp_q;
    end else begin : g_pp_narrow
      // One bit: set means M, clear means U. With no U mode it stays set.
      logic pp_m_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pp_m_q <= (LOW_PP == MODE_M);
        else        pp_m_q <= (mpp_nxt == MODE_M);
      end
      assign mpp = pp_m_q ? MODE_M : MODE_U;
    end
  endgenerate

endmodule

// File: rtl/priv_stack_slevel.sv
module priv_stack_slevel #(
  parameter bit EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_trap,
  input  logic ev_ret,
  input  logic ev_wr,
  input  logic from_s,
  input  logic wr_sie,
  input  logic wr_spie,
  input  logic wr_spp,
  output logic sie,
  output logic spie,
  output logic spp
);

  generate
    if (EN) begin : g_s_on
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sie  <= 1'b0;
          spie <= 1'b0;
          spp  <= 1'b0;
        end else if (ev_trap) begin
          spie <= sie;
          sie  <= 1'b0;
          spp  <= from_s;
        end else if (ev_ret) begin
          sie  <= spie;
          spie <= 1'b1;
          spp  <= 1'b0;
        end else if (ev_wr) begin
          sie  <= wr_sie;
          spie <= wr_spie;
          spp  <= wr_spp;
        end
      end
    end else begin : g_s_off
      logic unused_s_in;
      assign unused_s_in = ^{clk, rst_n, ev_trap, ev_ret, ev_wr, from_s, wr_sie, wr_spie, wr_spp};
      assign sie  = 1'b0;
      assign spie = 1'b0;
      assign spp  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/priv_stack.sv
module priv_stack
  import priv_stack_pkg::*;
#(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_req,
  input  logic [1:0]          trap_target,
  input  logic                mret_req,
  input  logic                sret_req,
  input  logic                csr_we,
  input  logic [STATUS_W-1:0] csr_wdata,
  output logic [1:0]          priv_mode,
  output logic [STATUS_W-1:0] status_rd
);

  // Supervisor level needs user mode beneath it.
  localparam bit S_ON = HAS_S && HAS_U;

  status_t    wr_f;
  logic [1:0] priv_q;
  logic       trap_to_s, trap_to_m;
  logic       do_mret, do_sret, do_wr;
  logic       mie, mpie, sie, spie, spp;
  logic [1:0] mpp;

  assign wr_f = status_t'(csr_wdata);

  // Event decode with fixed priority.
  assign trap_to_s = trap_req && S_ON && (trap_target == MODE_S) && (priv_q != MODE_M);
  assign trap_to_m = trap_req && !trap_to_s;
  assign do_mret   = !trap_req && mret_req;
  assign do_sret   = !trap_req && !mret_req && sret_req && S_ON;
  assign do_wr     = !trap_req && !mret_req && !do_sret && csr_we;

  priv_stack_mlevel #(
    .HAS_S (S_ON),
    .HAS_U (HAS_U)
  ) u_mlevel (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_trap  (trap_to_m),
    .ev_ret   (do_mret),
    .ev_wr    (do_wr),
    .cur_priv (priv_q),
    .wr_mie   (wr_f.mie),
    .wr_mpie  (wr_f.mpie),
    .wr_mpp   (wr_f.mpp),
    .mie      (mie),
    .mpie     (mpie),
    .mpp      (mpp)
  );

  priv_stack_slevel #(
    .EN (S_ON)
  ) u_slevel (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_trap (trap_to_s),
    .ev_ret  (do_sret),
    .ev_wr   (do_wr),
    .from_s  (priv_q == MODE_S),
    .wr_sie  (wr_f.sie),
    .wr_spie (wr_f.spie),
    .wr_spp  (wr_f.spp),
    .sie     (sie),
    .spie    (spie),
    .spp     (spp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         priv_q <= MODE_M;
    else if (trap_to_m) priv_q <= MODE_M;
    else if (trap_to_s) priv_q <= MODE_S;
    else if (do_mret)   priv_q <= mpp;
    else if (do_sret)   priv_q <= spp ? MODE_S : MODE_U;
  end

  assign priv_mode = priv_q;
  assign status_rd = {spie, mpie, sie, mie, spp, mpp};

endmodule

// File: rtl/priv_stack_chk.sv
module priv_stack_chk #(
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       trap_req,
  input logic [1:0] trap_target,
  input logic       mret_req,
  input logic       sret_req,
  input logic       csr_we,
  input logic [6:0] csr_wdata,
  input logic [1:0] priv_mode,
  input logic [6:0] status_rd
);

  localparam bit S_ON = HAS_S && HAS_U;

  logic       c_spie, c_mpie, c_sie, c_mie, c_spp;
  logic [1:0] c_mpp;
  logic       s_trap;

  assign {c_spie, c_mpie, c_sie, c_mie, c_spp, c_mpp} = status_rd;
  assign s_trap = trap_req && (trap_target == 2'd1) && S_ON && (priv_mode != 2'd3);

  p_priv_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mode != 2'd2) && (HAS_U || priv_mode == 2'd3) && (S_ON || priv_mode != 2'd1));

  p_trap_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !s_trap) |=> (priv_mode == 2'd3) && !c_mie &&
      (c_mpie == $past(c_mie)) && (c_mpp == $past(priv_mode)));

  p_trap_s_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_trap |=> (priv_mode == 2'd1) && !c_sie && (c_spie == $past(c_sie)) &&
      (c_spp == ($past(priv_mode) == 2'd1)));

  p_mret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && mret_req) |=> (priv_mode == $past(c_mpp)) && (c_mie == $past(c_mpie)) &&
      c_mpie && (c_mpp == (HAS_U ? 2'd0 : 2'd3)));

  p_sret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (S_ON && !trap_req && !mret_req && sret_req) |=>
      (priv_mode == ($past(c_spp) ? 2'd1 : 2'd0)) && (c_sie == $past(c_spie)) && c_spie && !c_spp);

  p_mpp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !trap_req && !mret_req && !(sret_req && S_ON) && csr_wdata[1:0] == 2'd2)
      |=> (c_mpp == $past(c_mpp)));

  p_s_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !S_ON |-> (!c_spie && !c_sie && !c_spp));

  p_no_u_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_U |-> (c_mpp == 2'd3));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !mret_req && !sret_req && !csr_we) |=> ($stable(status_rd) && $stable(priv_mode)));

endmodule

bind priv_stack priv_stack_chk #(
  .HAS_S (HAS_S),
  .HAS_U (HAS_U)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trap_req    (trap_req),
  .trap_target (trap_target),
  .mret_req    (mret_req),
  .sret_req    (sret_req),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .priv_mode   (priv_mode),
  .status_rd   (status_rd)
);

// File: tb/priv_stack_tb.sv
`timescale 1ns/1ps
module priv_stack_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trap_req = 1'b0;
  logic [1:0] trap_target = 2'd0;
  logic       mret_req = 1'b0;
  logic       sret_req = 1'b0;
  logic       csr_we = 1'b0;
  logic [6:0] csr_wdata = 7'd0;

  logic [1:0] pm_f, pm_mu, pm_m;
  logic [6:0] st_f, st_mu, st_m;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  priv_stack #(.HAS_S(1'b1), .HAS_U(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_target(trap_target),
    .mret_req(mret_req), .sret_req(sret_req), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .priv_mode(pm_f), .status_rd(st_f));

  priv_stack #(.HAS_S(1'b0), .HAS_U(1'b1)) u_dut_mu (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_target(trap_target),
    .mret_req(mret_req), .sret_req(sret_req), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .priv_mode(pm_mu), .status_rd(st_mu));

  priv_stack #(.HAS_S(1'b0), .HAS_U(1'b0)) u_dut_m (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_target(trap_target),
    .mret_req(mret_req), .sret_req(sret_req), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .priv_mode(pm_m), .status_rd(st_m));

  // {trap, target[1:0], mret, sret, we, wdata[6:0], exp_priv[1:0], exp_status[6:0]}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h19, 2'd3, 7'h19},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 2'd1, 7'h30},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 7'h00, 2'd1, 7'h64},
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 7'h00, 2'd1, 7'h70},
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 7'h00, 2'd3, 7'h51},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h0A, 2'd3, 7'h09},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 7'h00, 2'd3, 7'h23},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00, 2'd3, 7'h28},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 7'h7F, 2'd0, 7'h28},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 7'h00, 2'd1, 7'h28},
    {1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 7'h00, 2'd3, 7'h21},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h03, 2'd3, 7'h03},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h7C, 2'd3, 7'h7C},
    {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 7'h00, 2'd1, 7'h78},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 7'h00, 2'd1, 7'h78}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 5, 11, 12: return "R7 csr write";
      1, 7:         return "R5 mret";
      2, 6, 9:      return "R4 trap toward S";
      3, 13:        return "R6 sret";
      4:            return "R3 trap to M";
      default:      return "R9 priority/hold";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [1:0] gp, input logic [6:0] gs,
                     input logic [1:0] ep, input logic [6:0] es);
    n_chk++;
    if (gp !== ep || gs !== es) begin
      n_fail++;
      $display("FAIL %s: priv=%0d status=%02h expected priv=%0d status=%02h", tag, gp, gs, ep, es);
    end
  endtask

  // Drive at a falling edge; results are due after the next rising edge.
  task automatic apply(input logic t, input logic [1:0] tg, input logic mr, input logic sr,
                       input logic we, input logic [6:0] wd);
    trap_req = t; trap_target = tg; mret_req = mr; sret_req = sr; csr_we = we; csr_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    trap_req = 1'b0; trap_target = 2'd0; mret_req = 1'b0; sret_req = 1'b0; csr_we = 1'b0; csr_wdata = 7'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R2 reset state, R1 encodings
    chk("R2 reset full", pm_f, st_f, 2'd3, 7'h00);
    chk("R2 reset M+U", pm_mu, st_mu, 2'd3, 7'h00);
    chk("R2 reset M-only", pm_m, st_m, 2'd3, 7'h03);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][21], VEC[i][20:19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:9]);
      chk(vec_tag(i), pm_f, st_f, VEC[i][8:7], VEC[i][6:0]);
    end

    // Directed configuration tests, all builds from reset.
    do_reset();
    apply(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h7F);
    chk("R7 write all full", pm_f, st_f, 2'd3, 7'h7F);
    chk("R8 write all M+U (S bits zero)", pm_mu, st_mu, 2'd3, 7'h2B);
    chk("R8 write all M-only", pm_m, st_m, 2'd3, 7'h2B);

    apply(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h01);
    chk("R7 MPP=S full", pm_f, st_f, 2'd3, 7'h01);
    chk("R7 MPP=S refused M+U", pm_mu, st_mu, 2'd3, 7'h03);
    chk("R8 MPP=S refused M-only", pm_m, st_m, 2'd3, 7'h03);

    apply(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h00);
    chk("R7 MPP=U full", pm_f, st_f, 2'd3, 7'h00);
    chk("R7 MPP=U M+U", pm_mu, st_mu, 2'd3, 7'h00);
    chk("R8 MPP=U refused M-only", pm_m, st_m, 2'd3, 7'h03);

    apply(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 7'h00);
    chk("R6 sret to U full", pm_f, st_f, 2'd0, 7'h40);
    chk("R6 sret ignored M+U", pm_mu, st_mu, 2'd3, 7'h00);
    chk("R6 sret ignored M-only", pm_m, st_m, 2'd3, 7'h03);

    apply(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 7'h00);
    chk("R4 trap S from U full", pm_f, st_f, 2'd1, 7'h00);
    chk("R4 trap S taken to M, M+U", pm_mu, st_mu, 2'd3, 7'h03);
    chk("R4 trap S taken to M, M-only", pm_m, st_m, 2'd3, 7'h03);

    apply(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00);
    chk("R5 mret full", pm_f, st_f, 2'd0, 7'h20);
    chk("R5 mret M+U", pm_mu, st_mu, 2'd3, 7'h20);
    chk("R5 mret M-only keeps MPP=M", pm_m, st_m, 2'd3, 7'h23);

    // R1 priv never reaches 2 after an illegal MPP write and return
    apply(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 7'h02);
    apply(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 7'h00);
    chk("R1 illegal MPP then mret M+U", pm_mu, st_mu, 2'd0, 7'h20);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule